// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block keeps the interrupt state of one processor core for a space of 256 vectors. It holds three bitmaps: vectors that have been requested, vectors currently being serviced, and the trigger kind (level or edge) of each requested vector. Producers post fixed-mode requests on a request port. The block compares the highest requested vector against a processor priority and raises a pending flag with the vector to deliver. The processor priority is derived from a software task priority and the highest vector in service.

The core takes the offered vector with an acknowledge strobe. The vector moves from the request map to the in-service map and is returned on a pulse in the next cycle. When the handler finishes, an end-of-interrupt strobe retires the highest in-service vector. The block reports that vector together with its trigger kind, so that a level-triggered source can be re-armed. A global enable input gates both acceptance of requests and delivery.

Top module: `irqc_core`

## Requirements
- R1: After reset all three bitmaps and the task priority are zero. `int_pending_o`, `int_vec_o`, `ppr_o` and every pulse output read zero.
- R2: A request taken while enabled sets the vector's request bit. It sets the vector's trigger bit for level (`req_level_i`=1) and clears it for edge. One cycle later `req_accept_o` is high exactly when the request bit was clear beforehand.
- R3: A level request whose request bit is already set is discarded and leaves the trigger bit unchanged. An edge request whose bit is already set rewrites the trigger bit to edge. In both cases `req_accept_o` stays low.
- R4: While `enable_i` is low, requests change no state, `req_accept_o` stays low and `int_pending_o` is low.
- R5: `ppr_o` equals the task priority when its bits [7:4] are greater than or equal to bits [7:4] of the highest in-service vector. Otherwise it equals that vector with bits [3:0] cleared. An empty in-service map counts as vector 0.
- R6: `int_pending_o` is high only when enabled, some request bit is set, and the highest requested vector with bits [3:0] cleared is strictly greater than `ppr_o`. `int_vec_o` then carries that vector and is 0 otherwise. Both follow a state change in the next cycle.
- R7: An `ack_i` while `int_pending_o` is high sets the offered vector's in-service bit and clears its request bit. In the next cycle it raises `ack_done_o` with `ack_vec_o` equal to that vector. An `ack_i` with nothing pending has no effect.
- R8: An `eoi_i` clears the highest in-service bit. In the next cycle it pulses `eoi_done_o` with `eoi_vec_o` equal to that vector, and `eoi_level_o` equal to its trigger bit (1 level, 0 edge). The trigger bit is then cleared. With an empty in-service map, `eoi_i` does nothing.
- R9: A task-priority write (`tpr_we_i`, 8-bit value) takes effect on `ppr_o` and delivery in the following cycle.
- R10: Within one cycle, acknowledge and end-of-interrupt are both decided on the state before the edge. A request is then evaluated against the request map after that cycle's acknowledge clear. An end-of-interrupt trigger clear is overridden by a same-cycle request to the same vector.
- R11: Vector v is stored at bit v[4:0] of word v[7:5]. The search returns the numerically highest set vector across word boundaries, including vectors 0, 31, 32 and 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Unit enable; gates request acceptance and delivery |
| req_valid_i | input | 1 | Request strobe |
| req_vec_i | input | 8 | Requested vector |
| req_level_i | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| req_accept_o | output | 1 | Pulse: request produced a new pending bit |
| tpr_we_i | input | 1 | Task-priority write strobe |
| tpr_wdata_i | input | 8 | Task-priority write value |
| ack_i | input | 1 | Core acknowledges the offered vector |
| eoi_i | input | 1 | End-of-interrupt strobe |
| int_pending_o | output | 1 | A deliverable vector exists |
| int_vec_o | output | 8 | Vector offered for delivery |
| ppr_o | output | 8 | Current processor priority |
| ack_done_o | output | 1 | Pulse: acknowledge took effect |
| ack_vec_o | output | 8 | Vector moved into service |
| eoi_done_o | output | 1 | Pulse: a vector was retired |
| eoi_vec_o | output | 8 | Retired vector |
| eoi_level_o | output | 1 | Trigger kind of the retired vector (1 level) |

## Verification
The bench builds the block with its default parameters: an 8-bit vector and 32-bit words, so the full space of 256 vectors across eight words. That makes the word seams at 31/32 and the extreme vectors 0 and 255 reachable, as well as every 16-vector priority class. Random traffic is drawn mostly from a few low nibbles in each class. This forces repeated requests on busy vectors, nested service across classes, and same-cycle request, acknowledge and end-of-interrupt collisions on a single vector.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Priority class occupies the vector bits above this position.
    localparam int CLASS_LSB = 4;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

endpackage

// File: rtl/irqc_find_high.sv
module irqc_find_high #(
    parameter  int VEC_W     = 8,
    parameter  int WORD_W    = 32,
    localparam int NUM_WORDS = (1 << VEC_W) / WORD_W
) (
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] map_i,
    output logic                             found_o,
    output logic [VEC_W-1:0]                 vec_o
);

    localparam int BIT_W  = $clog2(WORD_W);
    localparam int WSEL_W = VEC_W - BIT_W;

    logic [NUM_WORDS-1:0]            word_any;
    logic [NUM_WORDS-1:0][BIT_W-1:0] word_bit;

    // First level: highest set bit inside each word, all words in parallel.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic             any_w;
        logic [BIT_W-1:0] bit_w;

        always_comb begin
            any_w = |map_i[w];
            bit_w = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (map_i[w][b]) begin
                    bit_w = BIT_W'(b);
                end
            end
        end

        assign word_any[w] = any_w;
        assign word_bit[w] = bit_w;
    end

    // Second level: highest non-empty word selects the result.
    always_comb begin
        found_o = |word_any;
        vec_o   = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_any[w]) begin
                vec_o = {WSEL_W'(w), word_bit[w]};
            end
        end
    end

endmodule

// File: rtl/irqc_prio_calc.sv
module irqc_prio_calc
    import irqc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] tpr_i,
    input  logic             isr_found_i,
    input  logic [VEC_W-1:0] isr_vec_i,
    output logic [VEC_W-1:0] ppr_o
);

    localparam int CLS_W = VEC_W - CLASS_LSB;

    logic [CLS_W-1:0] tpr_cls;
    logic [CLS_W-1:0] isr_cls;

    always_comb begin
        tpr_cls = tpr_i[VEC_W-1:CLASS_LSB];
        isr_cls = isr_found_i ? isr_vec_i[VEC_W-1:CLASS_LSB] : '0;
        if (tpr_cls >= isr_cls) begin
            ppr_o = tpr_i;
        end else begin
            ppr_o = {isr_cls, {CLASS_LSB{1'b0}}};
        end
    end

endmodule

// File: rtl/irqc_deliver.sv
module irqc_deliver
    import irqc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             enable_i,
    input  logic             irr_found_i,
    input  logic [VEC_W-1:0] irr_vec_i,
    input  logic [VEC_W-1:0] ppr_i,
    output logic             pending_o,
    output logic [VEC_W-1:0] vec_o
);

    logic [VEC_W-1:0] irr_class;

    always_comb begin
        irr_class = {irr_vec_i[VEC_W-1:CLASS_LSB], {CLASS_LSB{1'b0}}};
        pending_o = enable_i && irr_found_i && (irr_class > ppr_i);
        vec_o     = pending_o ? irr_vec_i : '0;
    end

endmodule

// File: rtl/irqc_core.sv
module irqc_core
    import irqc_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int WORD_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             req_valid_i,
    input  logic [VEC_W-1:0] req_vec_i,
    input  logic             req_level_i,
    output logic             req_accept_o,
    input  logic             tpr_we_i,
    input  logic [VEC_W-1:0] tpr_wdata_i,
    input  logic             ack_i,
    input  logic             eoi_i,
    output logic             int_pending_o,
    output logic [VEC_W-1:0] int_vec_o,
    output logic [VEC_W-1:0] ppr_o,
    output logic             ack_done_o,
    output logic [VEC_W-1:0] ack_vec_o,
    output logic             eoi_done_o,
    output logic [VEC_W-1:0] eoi_vec_o,
    output logic             eoi_level_o
);

    localparam int NUM_VEC   = 1 << VEC_W;
    localparam int NUM_WORDS = NUM_VEC / WORD_W;
    localparam int BIT_W     = $clog2(WORD_W);

    typedef logic [NUM_WORDS-1:0][WORD_W-1:0] map_t;

    typedef struct packed {
        map_t             irr;
        map_t             isr;
        map_t             tmr;
        logic [VEC_W-1:0] tpr;
        logic             accept;
        logic             ack_done;
        logic [VEC_W-1:0] ack_vec;
        logic             eoi_done;
        logic [VEC_W-1:0] eoi_vec;
        trig_e            eoi_trig;
    } state_t;

    state_t state_d, state_q;

    // Derived views of the registered state.
    logic             irr_found, isr_found;
    logic [VEC_W-1:0] irr_top, isr_top;
    logic [VEC_W-1:0] ppr;
    logic             deliver;
    logic [VEC_W-1:0] deliver_vec;
    logic [VEC_W-1:0] tpr_q;

    assign tpr_q = state_q.tpr;

    irqc_find_high #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_find_irr (
        .map_i   (state_q.irr),
        .found_o (irr_found),
        .vec_o   (irr_top)
    );

    irqc_find_high #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_find_isr (
        .map_i   (state_q.isr),
        .found_o (isr_found),
        .vec_o   (isr_top)
    );

    irqc_prio_calc #(.VEC_W(VEC_W)) u_prio (
        .tpr_i       (state_q.tpr),
        .isr_found_i (isr_found),
        .isr_vec_i   (isr_top),
        .ppr_o       (ppr)
    );

    irqc_deliver #(.VEC_W(VEC_W)) u_deliver (
        .enable_i    (enable_i),
        .irr_found_i (irr_found),
        .irr_vec_i   (irr_top),
        .ppr_i       (ppr),
        .pending_o   (deliver),
        .vec_o       (deliver_vec)
    );

    // Next-state computation. Acknowledge and retirement act on the state
    // before the edge; the request then sees the request map after the
    // acknowledge clear.
    always_comb begin
        logic prev_set;

        state_d          = state_q;
        state_d.accept   = 1'b0;
        state_d.ack_done = 1'b0;
        state_d.ack_vec  = '0;
        state_d.eoi_done = 1'b0;
        state_d.eoi_vec  = '0;
        state_d.eoi_trig = TRIG_EDGE;
        prev_set         = 1'b0;

        if (ack_i && deliver) begin
            state_d.isr[deliver_vec[VEC_W-1:BIT_W]][deliver_vec[BIT_W-1:0]] = 1'b1;
            state_d.irr[deliver_vec[VEC_W-1:BIT_W]][deliver_vec[BIT_W-1:0]] = 1'b0;
            state_d.ack_done = 1'b1;
            state_d.ack_vec  = deliver_vec;
        end

        if (eoi_i && isr_found) begin
            state_d.isr[isr_top[VEC_W-1:BIT_W]][isr_top[BIT_W-1:0]] = 1'b0;
            state_d.eoi_done = 1'b1;
            state_d.eoi_vec  = isr_top;
            state_d.eoi_trig = trig_e'(state_q.tmr[isr_top[VEC_W-1:BIT_W]][isr_top[BIT_W-1:0]]);
            state_d.tmr[isr_top[VEC_W-1:BIT_W]][isr_top[BIT_W-1:0]] = 1'b0;
        end

        if (tpr_we_i) begin
            state_d.tpr = tpr_wdata_i;
        end

        if (req_valid_i && enable_i) begin
            prev_set = state_d.irr[req_vec_i[VEC_W-1:BIT_W]][req_vec_i[BIT_W-1:0]];
            if (!(prev_set && req_level_i)) begin
                state_d.irr[req_vec_i[VEC_W-1:BIT_W]][req_vec_i[BIT_W-1:0]] = 1'b1;
                state_d.tmr[req_vec_i[VEC_W-1:BIT_W]][req_vec_i[BIT_W-1:0]] = req_level_i;
                state_d.accept = !prev_set;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_accept_o  = state_q.accept;
    assign int_pending_o = deliver;
    assign int_vec_o     = deliver_vec;
    assign ppr_o         = ppr;
    assign ack_done_o    = state_q.ack_done;
    assign ack_vec_o     = state_q.ack_vec;
    assign eoi_done_o    = state_q.eoi_done;
    assign eoi_vec_o     = state_q.eoi_vec;
    assign eoi_level_o   = (state_q.eoi_trig == TRIG_LEVEL);

endmodule

// File: rtl/irqc_core_chk.sv
module irqc_core_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             enable_i,
    input logic             req_valid_i,
    input logic             ack_i,
    input logic             eoi_i,
    input logic             isr_found,
    input logic [VEC_W-1:0] tpr_q,
    input logic             req_accept_o,
    input logic             int_pending_o,
    input logic [VEC_W-1:0] int_vec_o,
    input logic [VEC_W-1:0] ppr_o,
    input logic             ack_done_o,
    input logic [VEC_W-1:0] ack_vec_o,
    input logic             eoi_done_o
);

    // R4: nothing is delivered while the unit is disabled
    p_no_delivery_disabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |-> !int_pending_o);

    // R4: a request presented while disabled is never accepted
    p_no_accept_disabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !enable_i) |=> !req_accept_o);

    // R5: processor priority never falls below the task priority
    p_ppr_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ppr_o >= tpr_q);

    // R6: an offered vector's class lies strictly above the processor priority
    p_class_above_ppr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_pending_o |-> ({int_vec_o[VEC_W-1:4], 4'b0000} > ppr_o));

    // R7: acknowledge returns the vector that was offered
    p_ack_returns_vec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && int_pending_o) |=> (ack_done_o && ack_vec_o == $past(int_vec_o)));

    // R7: acknowledge with nothing pending is ignored
    p_ack_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !int_pending_o) |=> !ack_done_o);

    // R8: retirement with an empty in-service map does nothing
    p_eoi_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_i && !isr_found) |=> !eoi_done_o);

    // R8: a retirement pulse always follows a retirement strobe
    p_eoi_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eoi_done_o |-> $past(eoi_i));

endmodule

bind irqc_core irqc_core_chk #(.VEC_W(VEC_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .req_valid_i   (req_valid_i),
    .ack_i         (ack_i),
    .eoi_i         (eoi_i),
    .isr_found     (isr_found),
    .tpr_q         (tpr_q),
    .req_accept_o  (req_accept_o),
    .int_pending_o (int_pending_o),
    .int_vec_o     (int_vec_o),
    .ppr_o         (ppr_o),
    .ack_done_o    (ack_done_o),
    .ack_vec_o     (ack_vec_o),
    .eoi_done_o    (eoi_done_o)
);

// File: tb/irqc_core_tb_top.sv
`timescale 1ns/1ps
module irqc_core_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       enable_i = 1'b0;
    logic       req_valid_i = 1'b0;
    logic [7:0] req_vec_i = '0;
    logic       req_level_i = 1'b0;
    logic       tpr_we_i = 1'b0;
    logic [7:0] tpr_wdata_i = '0;
    logic       ack_i = 1'b0;
    logic       eoi_i = 1'b0;
    logic       req_accept_o, int_pending_o, ack_done_o, eoi_done_o, eoi_level_o;
    logic [7:0] int_vec_o, ppr_o, ack_vec_o, eoi_vec_o;

    always #2.5 clk_i = ~clk_i;

    irqc_core dut_i (
        .clk_i, .rst_ni, .enable_i, .req_valid_i, .req_vec_i, .req_level_i,
        .req_accept_o, .tpr_we_i, .tpr_wdata_i, .ack_i, .eoi_i,
        .int_pending_o, .int_vec_o, .ppr_o, .ack_done_o, .ack_vec_o,
        .eoi_done_o, .eoi_vec_o, .eoi_level_o
    );

    // Behavioural reference model
    logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
    int m_tpr = 0;
    bit m_en = 0;
    bit e_accept = 0, e_ack = 0, e_eoi = 0, e_lvl = 0;
    int e_ack_vec = 0, e_eoi_vec = 0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    function automatic int highest(logic [255:0] m);
        for (int v = 255; v >= 0; v--) if (m[v]) return v;
        return -1;
    endfunction

    function automatic int prio(int tpr, int isr_hi);
        int c = (isr_hi < 0) ? 0 : (isr_hi / 16);
        if (tpr / 16 >= c) return tpr;
        return c * 16;
    endfunction

    function automatic bit pending_now(bit en);
        int hi = highest(m_irr);
        int pp = prio(m_tpr, highest(m_isr));
        return en && hi >= 0 && ((hi / 16) * 16) > pp;
    endfunction

    task automatic chk(string tag, string what, int got, int exp);
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic compare();
        bit p = pending_now(m_en);
        checks++;
        chk("R5/R9", "ppr_o", int'(ppr_o), prio(m_tpr, highest(m_isr)));
        chk("R6/R11", "int_pending_o", int'(int_pending_o), int'(p));
        chk("R6/R11", "int_vec_o", int'(int_vec_o), p ? highest(m_irr) : 0);
        chk("R2/R3/R4/R10", "req_accept_o", int'(req_accept_o), int'(e_accept));
        chk("R7", "ack_done_o", int'(ack_done_o), int'(e_ack));
        chk("R7", "ack_vec_o", int'(ack_vec_o), e_ack_vec);
        chk("R8", "eoi_done_o", int'(eoi_done_o), int'(e_eoi));
        chk("R8", "eoi_vec_o", int'(eoi_vec_o), e_eoi_vec);
        chk("R8", "eoi_level_o", int'(eoi_level_o), int'(e_lvl));
    endtask

    task automatic step(bit en, bit rv, int rvec, bit rlvl, bit ack, bit eoi, bit twe, int tdat);
        int hi_irr = highest(m_irr);
        int hi_isr = highest(m_isr);
        bit p = pending_now(en);
        bit old;
        e_accept = 0; e_ack = 0; e_eoi = 0; e_lvl = 0; e_ack_vec = 0; e_eoi_vec = 0;
        if (ack && p) begin
            m_isr[hi_irr] = 1'b1; m_irr[hi_irr] = 1'b0; e_ack = 1; e_ack_vec = hi_irr;
        end
        if (eoi && hi_isr >= 0) begin
            m_isr[hi_isr] = 1'b0; e_eoi = 1; e_eoi_vec = hi_isr;
            e_lvl = m_tmr[hi_isr]; m_tmr[hi_isr] = 1'b0;
        end
        if (twe) m_tpr = tdat;
        if (rv && en) begin
            old = m_irr[rvec];
            if (!(old && rlvl)) begin
                m_irr[rvec] = 1'b1; m_tmr[rvec] = rlvl; e_accept = !old;
            end
        end
        m_en = en;
    endtask

    task automatic apply(bit en, bit rv, int rvec, bit rlvl, bit ack, bit eoi, bit twe, int tdat);
        @(negedge clk_i);
        compare();
        enable_i = en; req_valid_i = rv; req_vec_i = 8'(rvec); req_level_i = rlvl;
        ack_i = ack; eoi_i = eoi; tpr_we_i = twe; tpr_wdata_i = 8'(tdat);
        step(en, rv, rvec, rlvl, ack, eoi, twe, tdat);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) apply(1, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        // R1: reset state
        checks++;
        chk("R1", "reset int_pending_o", int'(int_pending_o), 0);
        chk("R1", "reset ppr_o", int'(ppr_o), 0);
        chk("R1", "reset pulses", int'({req_accept_o, ack_done_o, eoi_done_o}), 0);
        rst_ni = 1'b1;

        // R2: edge request accepted and delivered
        apply(1, 1, 'h45, 0, 0, 0, 0, 0);
        idle(1);
        // R3: level repeat on a set vector is discarded
        apply(1, 1, 'h45, 1, 0, 0, 0, 0);
        // R9: task priority gates delivery by class
        apply(1, 0, 0, 0, 0, 0, 1, 'h50);
        idle(1);
        apply(1, 0, 0, 0, 0, 0, 1, 'h3F);
        idle(1);
        // R7: acknowledge, then same-class request stays blocked
        apply(1, 0, 0, 0, 1, 0, 0, 0);
        apply(1, 1, 'h4A, 0, 0, 0, 0, 0);
        apply(1, 1, 'h81, 1, 0, 0, 0, 0);
        apply(1, 0, 0, 0, 1, 0, 0, 0);
        // R8: nested retirement, level then edge
        apply(1, 0, 0, 0, 0, 1, 0, 0);
        apply(1, 0, 0, 0, 0, 1, 0, 0);
        apply(1, 0, 0, 0, 0, 1, 0, 0);
        // R8: trigger bit cleared by retirement (re-request, ack, retire twice)
        apply(1, 1, 'h90, 1, 0, 0, 1, 0);
        apply(1, 0, 0, 0, 1, 0, 0, 0);
        apply(1, 1, 'h90, 1, 0, 0, 0, 0);
        apply(1, 0, 0, 0, 0, 1, 0, 0);
        apply(1, 0, 0, 0, 1, 0, 0, 0);
        apply(1, 0, 0, 0, 0, 1, 0, 0);
        // R11: word seams and extremes
        apply(1, 1, 'h1F, 0, 0, 0, 0, 0);
        apply(1, 1, 'h20, 1, 0, 0, 0, 0);
        apply(1, 1, 'h00, 0, 0, 0, 0, 0);
        apply(1, 1, 'hFF, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) apply(1, 0, 0, 0, 1, 0, 0, 0);
        for (int i = 0; i < 4; i++) apply(1, 0, 0, 0, 0, 1, 0, 0);
        // R4: disabled unit drops requests and delivers nothing
        apply(0, 1, 'h70, 1, 0, 0, 0, 0);
        apply(0, 0, 0, 0, 1, 0, 0, 0);
        idle(2);
        // R10: same-cycle acknowledge and request on the offered vector
        apply(1, 1, 'h60, 0, 0, 0, 0, 0);
        apply(1, 1, 'h60, 1, 1, 0, 0, 0);
        apply(1, 1, 'h60, 0, 0, 1, 0, 0);
        idle(2);

        // Random traffic over a narrow vector pool
        for (int i = 0; i < 6000; i++) begin
            bit en = ($urandom_range(0, 99) >= 4);
            int vec = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 255)
                      : ($urandom_range(1, 15) * 16 + $urandom_range(0, 2));
            int td = $urandom_range(0, 1) ? $urandom_range(0, 'h5F) : $urandom_range(0, 255);
            apply(en, $urandom_range(0, 99) < 40, vec, $urandom_range(0, 1) == 1,
                  $urandom_range(0, 99) < 30, $urandom_range(0, 99) < 22,
                  $urandom_range(0, 99) < 4, td);
        end
        idle(40);
        for (int i = 0; i < 40; i++) apply(1, 0, 0, 0, 1, 1, i == 0, 0);
        idle(1);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule